// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the host-facing port of a character display controller. A host processor talks to it over a parallel bus that uses one of two conventions. The first has separate active-low read and write strobes. The second has one enable strobe and a read/write level. A static strap pin picks the convention. The data path is either a full byte or a pair of nibbles carried on the upper four data lines. The width is not a pin: the port watches completed instruction writes and takes the width from the interface-width bit of the function-set instruction.

The strobe, direction, select and data pins are asynchronous to the controller clock, so they pass through a configurable synchronizer before any edge is detected. Each completed byte produces a one-cycle access pulse. The pulse carries a two-bit access kind and, for writes, the assembled byte. That pulse goes to the controller core. The core in turn supplies the busy flag, the address counter and the read-data byte. The port places these on the bus while a read strobe is active, and releases the bus at all other times.

Top module: `hbus_port`

## Requirements
- R1: After reset the port is in full-byte width and expects the high nibble first. It gives no access pulse and does not enable its bus output until the host makes an access.
- R2: With `strap_i80` high, a write completes on the rising edge of `wr_n_i`. The data used is the bus value sampled while the strobe was still low. `acc_valid_o` is high for exactly one cycle, on the (SYNC_STAGES+1)th rising clock edge after the strobe edge reaches the pins.
- R3: With `strap_i80` low, a write completes on the falling edge of `en_i` while `rw_i` is low. A read completes on the same edge while `rw_i` is high. The latency is the same as in R2.
- R4: The access kind is `{rs, direction}`, with direction 1 for a read. 00 is an instruction write, 01 is a status read, 10 is a data write and 11 is a data read. For writes, `acc_data_o` carries the byte.
- R5: `db_oe_o` is high only while a read strobe is active. That means `rd_n_i` is low in strobe mode, or `en_i` and `rw_i` are both high in enable mode. With `rs_i` low the driven byte is `{busy_i, addr_i}`. With `rs_i` high it is `rdata_i`.
- R6: A read produces its access pulse when the read strobe ends, with `acc_data_o` equal to zero.
- R7: In nibble width, a write takes two transfers on DB7..DB4, high nibble first. Only the second transfer gives an access pulse, which carries the joined byte.
- R8: In nibble width, the first read drives the byte's high nibble on DB7..DB4 and the second read drives its low nibble. DB3..DB0 read as zero. Only the second read gives an access pulse.
- R9: A write transfer that would begin a byte (the full byte, or the high nibble) is dropped if `busy_i` is high in the cycle it is processed. A dropped transfer gives no pulse and does not change the nibble phase. A low-nibble write is taken whatever `busy_i` is.
- R10: A completed instruction write whose upper three bits are 001 sets the width from bit 4 (1 = full byte, 0 = nibble pairs). The next transfer is then a high nibble.
- R11: Strobes that belong to the protocol the strap does not select are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i80 | input | 1 | 1: separate read/write strobes, 0: enable strobe with read/write level |
| rs_i | input | 1 | Register select, 0 instruction/status, 1 data |
| rw_i | input | 1 | Read/write level for enable mode, 1 = read |
| en_i | input | 1 | Enable strobe for enable mode, active high |
| wr_n_i | input | 1 | Write strobe for strobe mode, active low |
| rd_n_i | input | 1 | Read strobe for strobe mode, active low |
| db_i | input | DATA_W | Bus data from host |
| db_o | output | DATA_W | Bus data to host |
| db_oe_o | output | 1 | Bus output enable for the pad tri-state |
| busy_i | input | 1 | Core busy flag |
| addr_i | input | DATA_W-1 | Core address counter |
| rdata_i | input | DATA_W | Core read-data byte |
| acc_valid_o | output | 1 | One-cycle access pulse |
| acc_type_o | output | 2 | Access kind, see R4 |
| acc_data_o | output | DATA_W | Written byte, zero for reads |

## Verification
The busy flag and the processing of a byte-opening write can fall in the same clock cycle. Whether that write is dropped depends on the exact cycle in which `busy_i` rises relative to the synchronized strobe edge. The bench releases the write strobe and then raises `busy_i` after a sweep of delays, from zero cycles to several. It does this in both widths, and also around a low-nibble write. For each case the reference model decides, from the inputs it saw at every clock, whether a pulse is due, and the design is compared with the model every cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [1:0] {
      ACC_INSTR_WR  = 2'b00,
      ACC_STATUS_RD = 2'b01,
      ACC_DATA_WR   = 2'b10,
      ACC_DATA_RD   = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic wr_n;
      logic rd_n;
      logic en;
      logic rw;
      logic rs;
   } ctl_s;

   localparam int CTL_W = $bits(ctl_s);
   localparam ctl_s CTL_IDLE = '{wr_n: 1'b1, rd_n: 1'b1, en: 1'b0, rw: 1'b0, rs: 1'b0};

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("hbus_sync: STAGES must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("hbus_sync: W must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [W-1:0] src;
         logic [W-1:0] r;
         if (i == 0) begin : g_first
            assign src = d;
         end else begin : g_next
            assign src = g_stage[i-1].r;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= IDLE;
            else        r <= src;
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/hbus_strobe_dec.sv
module hbus_strobe_dec (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strap_i80,
   input  hbus_pkg::ctl_s  cur,
   output logic            wr_evt,
   output logic            rd_evt,
   output logic            rs_o
);
   import hbus_pkg::*;

   ctl_s old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) old <= CTL_IDLE;
      else        old <= cur;
   end

   logic en_fall;
   assign en_fall = old.en & ~cur.en;

   always_comb begin
      if (strap_i80) begin
         wr_evt = ~old.wr_n & cur.wr_n;
         rd_evt = ~old.rd_n & cur.rd_n & ~wr_evt;
      end else begin
         wr_evt = en_fall & ~old.rw;
         rd_evt = en_fall &  old.rw;
      end
   end

   assign rs_o = old.rs;

endmodule

// File: rtl/hbus_nibble_asm.sv
module hbus_nibble_asm #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_evt,
   input  logic              rd_evt,
   input  logic              rs,
   input  logic [DATA_W-1:0] db,
   input  logic              busy,
   output logic              acc_valid,
   output logic [1:0]        acc_type,
   output logic [DATA_W-1:0] acc_data,
   output logic              phase_hi,
   output logic              width_full
);
   import hbus_pkg::*;

   localparam int NIB    = DATA_W / 2;
   localparam int IF_BIT = DATA_W - 4;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("hbus_nibble_asm: DATA_W must be even and at least 8");
      end
   endgenerate

   logic [NIB-1:0]    hi_nib, nxt_hi;
   logic              nxt_phase;
   logic              done, is_rd, fset;
   logic [DATA_W-1:0] byte_c;
   acc_kind_e         kind;

   always_comb begin
      done      = 1'b0;
      is_rd     = 1'b0;
      nxt_phase = phase_hi;
      nxt_hi    = hi_nib;
      byte_c    = db;
      if (wr_evt) begin
         if (!(phase_hi && busy)) begin
            if (width_full) begin
               done = 1'b1;
            end else if (phase_hi) begin
               nxt_hi    = db[DATA_W-1 -: NIB];
               nxt_phase = 1'b0;
            end else begin
               done   = 1'b1;
               byte_c = {hi_nib, db[DATA_W-1 -: NIB]};
            end
         end
      end else if (rd_evt) begin
         is_rd = 1'b1;
         if (width_full)    done      = 1'b1;
         else if (phase_hi) nxt_phase = 1'b0;
         else               done      = 1'b1;
      end
      if (done) nxt_phase = 1'b1;
      fset = done && !is_rd && !rs && (byte_c[DATA_W-1 -: 3] == 3'b001);
      kind = acc_kind_e'({rs, is_rd});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_hi   <= 1'b1;
         width_full <= 1'b1;
         hi_nib     <= '0;
         acc_valid  <= 1'b0;
         acc_type   <= ACC_INSTR_WR;
         acc_data   <= '0;
      end else begin
         acc_valid <= done;
         phase_hi  <= nxt_phase;
         hi_nib    <= nxt_hi;
         if (done) begin
            acc_type <= kind;
            acc_data <= is_rd ? '0 : byte_c;
         end
         if (fset) begin
            width_full <= byte_c[IF_BIT];
            phase_hi   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hbus_rd_mux.sv
module hbus_rd_mux #(
   parameter int DATA_W = 8
) (
   input  logic              strap_i80,
   input  logic              rd_n,
   input  logic              en,
   input  logic              rw,
   input  logic              rs,
   input  logic              busy,
   input  logic [DATA_W-2:0] addr,
   input  logic [DATA_W-1:0] rdata,
   input  logic              width_full,
   input  logic              phase_hi,
   output logic [DATA_W-1:0] db_o,
   output logic              db_oe
);

   localparam int NIB = DATA_W / 2;

   logic              strobe_on;
   logic [DATA_W-1:0] src_byte;
   logic [NIB-1:0]    nib_sel;
   logic [DATA_W-1:0] shaped;

   assign strobe_on = strap_i80 ? ~rd_n : (en & rw);
   assign src_byte  = rs ? rdata : {busy, addr};
   assign nib_sel   = phase_hi ? src_byte[DATA_W-1 -: NIB] : src_byte[NIB-1:0];

   generate
      if (NIB * 2 == DATA_W) begin : g_even
         assign shaped = width_full ? src_byte : {nib_sel, {NIB{1'b0}}};
      end else begin : g_bad
         $error("hbus_rd_mux: DATA_W must be even");
      end
   endgenerate

   assign db_oe = strobe_on;
   assign db_o  = strobe_on ? shaped : '0;

endmodule

// File: rtl/hbus_port.sv
module hbus_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_i80,
   input  logic              rs_i,
   input  logic              rw_i,
   input  logic              en_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic [DATA_W-1:0] db_i,
   output logic [DATA_W-1:0] db_o,
   output logic              db_oe_o,
   input  logic              busy_i,
   input  logic [DATA_W-2:0] addr_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              acc_valid_o,
   output logic [1:0]        acc_type_o,
   output logic [DATA_W-1:0] acc_data_o
);
   import hbus_pkg::*;

   localparam int DB_STAGES = SYNC_STAGES + 1;

   ctl_s              ctl_raw, ctl_cur;
   logic [DATA_W-1:0] db_old;
   logic              wr_evt, rd_evt, rs_old;
   logic              phase_hi, width_full;

   assign ctl_raw = '{wr_n: wr_n_i, rd_n: rd_n_i, en: en_i, rw: rw_i, rs: rs_i};

   hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .IDLE(CTL_IDLE)) u_ctl_sync (
      .clk (clk), .rst_n (rst_n), .d (ctl_raw), .q (ctl_cur)
   );

   hbus_sync #(.W(DATA_W), .STAGES(DB_STAGES), .IDLE('0)) u_db_sync (
      .clk (clk), .rst_n (rst_n), .d (db_i), .q (db_old)
   );

   hbus_strobe_dec u_dec (
      .clk (clk), .rst_n (rst_n), .strap_i80 (strap_i80), .cur (ctl_cur),
      .wr_evt (wr_evt), .rd_evt (rd_evt), .rs_o (rs_old)
   );

   hbus_nibble_asm #(.DATA_W(DATA_W)) u_asm (
      .clk (clk), .rst_n (rst_n), .wr_evt (wr_evt), .rd_evt (rd_evt), .rs (rs_old),
      .db (db_old), .busy (busy_i), .acc_valid (acc_valid_o), .acc_type (acc_type_o),
      .acc_data (acc_data_o), .phase_hi (phase_hi), .width_full (width_full)
   );

   hbus_rd_mux #(.DATA_W(DATA_W)) u_rmux (
      .strap_i80 (strap_i80), .rd_n (rd_n_i), .en (en_i), .rw (rw_i), .rs (rs_i),
      .busy (busy_i), .addr (addr_i), .rdata (rdata_i), .width_full (width_full),
      .phase_hi (phase_hi), .db_o (db_o), .db_oe (db_oe_o)
   );

endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_type,
   input logic [DATA_W-1:0] acc_data,
   input logic              db_oe,
   input logic [DATA_W-1:0] db_out,
   input logic              width_full,
   input logic              phase_hi,
   input logic              wr_evt,
   input logic              busy
);

   localparam int NIB = DATA_W / 2;

   // R9
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && phase_hi && busy) |=> !acc_valid);

   // R8
   low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_oe && !width_full) |-> (db_out[NIB-1:0] == '0));

   // R10
   width_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(width_full) |-> phase_hi);

   // R7
   full_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      width_full |-> phase_hi);

   // R6
   read_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_type[0]) |-> (acc_data == '0));

   // R2
   write_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_type[0]) |=> !(acc_valid && !acc_type[0]));

endmodule

bind hbus_port hbus_port_chk #(.DATA_W(DATA_W)) chk_i (
   .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid_o), .acc_type (acc_type_o),
   .acc_data (acc_data_o), .db_oe (db_oe_o), .db_out (db_o), .width_full (width_full),
   .phase_hi (phase_hi), .wr_evt (wr_evt), .busy (busy_i)
);

// File: tb/hbus_port_tb_top.sv
module hbus_port_tb_top;

   localparam int N = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       p_i80 = 1'b1, p_rs = 1'b0, p_rw = 1'b0, p_en = 1'b0;
   logic       p_wr_n = 1'b1, p_rd_n = 1'b1, p_busy = 1'b0;
   logic [7:0] p_db = 8'h00, p_rdata = 8'h00;
   logic [6:0] p_addr = 7'h00;

   logic [7:0] db_o, acc_data_o;
   logic       db_oe_o, acc_valid_o;
   logic [1:0] acc_type_o;

   hbus_port #(.DATA_W(8), .SYNC_STAGES(N)) dut_i (
      .clk (clk), .rst_n (rst_n), .strap_i80 (p_i80), .rs_i (p_rs), .rw_i (p_rw),
      .en_i (p_en), .wr_n_i (p_wr_n), .rd_n_i (p_rd_n), .db_i (p_db), .db_o (db_o),
      .db_oe_o (db_oe_o), .busy_i (p_busy), .addr_i (p_addr), .rdata_i (p_rdata),
      .acc_valid_o (acc_valid_o), .acc_type_o (acc_type_o), .acc_data_o (acc_data_o)
   );

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    bench_full = 1'b1;

   typedef struct {
      logic wr_n, rd_n, en, rw, rs;
      logic [7:0] db;
   } snap_t;

   snap_t      hist[$];
   bit         m_full, m_hi, e_valid;
   logic [3:0] m_nib;
   logic [1:0] e_type;
   logic [7:0] e_data;

   function automatic snap_t idle_snap();
      snap_t s;
      s.wr_n = 1'b1; s.rd_n = 1'b1; s.en = 1'b0; s.rw = 1'b0; s.rs = 1'b0; s.db = 8'h00;
      return s;
   endfunction

   // Reference model: processes the strobe edge seen N cycles back
   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i <= N; i++) hist.push_back(idle_snap());
         m_full = 1'b1; m_hi = 1'b1; m_nib = 4'h0; e_valid = 1'b0;
         e_type = 2'b00; e_data = 8'h00;
      end else begin
         snap_t s, cur, old;
         bit wr, rd, fin, rdk;
         logic [7:0] byt;
         s.wr_n = p_wr_n; s.rd_n = p_rd_n; s.en = p_en; s.rw = p_rw; s.rs = p_rs; s.db = p_db;
         hist.push_back(s);
         while (hist.size() > N + 2) void'(hist.pop_front());
         cur = hist[hist.size()-1-N];
         old = hist[hist.size()-2-N];
         if (p_i80) begin
            wr = !old.wr_n && cur.wr_n;
            rd = !old.rd_n && cur.rd_n && !wr;
         end else begin
            wr = old.en && !cur.en && !old.rw;
            rd = old.en && !cur.en && old.rw;
         end
         fin = 1'b0; rdk = 1'b0; byt = old.db;
         if (wr) begin
            if (!(m_hi && p_busy)) begin
               if (m_full) fin = 1'b1;
               else if (m_hi) begin m_nib = old.db[7:4]; m_hi = 1'b0; end
               else begin byt = {m_nib, old.db[7:4]}; fin = 1'b1; end
            end
         end else if (rd) begin
            rdk = 1'b1;
            if (m_full) fin = 1'b1;
            else if (m_hi) m_hi = 1'b0;
            else fin = 1'b1;
         end
         e_valid = fin;
         if (fin) begin
            m_hi   = 1'b1;
            e_type = {old.rs, rdk};
            e_data = rdk ? 8'h00 : byt;
            if (!rdk && !old.rs && byt[7:5] == 3'b001) m_full = byt[4];
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit         x_oe;
         logic [7:0] x_byte, x_db;
         checks++;
         if (acc_valid_o !== e_valid || (e_valid && (acc_type_o !== e_type || acc_data_o !== e_data))) begin
            failures++;
            $display("FAIL %s access: got v=%0b t=%0d d=%02h, expected v=%0b t=%0d d=%02h",
                     cur_req, acc_valid_o, acc_type_o, acc_data_o, e_valid, e_type, e_data);
         end
         x_oe   = p_i80 ? !p_rd_n : (p_en && p_rw);
         x_byte = p_rs ? p_rdata : {p_busy, p_addr};
         x_db   = m_full ? x_byte : (m_hi ? {x_byte[7:4], 4'h0} : {x_byte[3:0], 4'h0});
         checks++;
         if (db_oe_o !== x_oe || (x_oe && db_o !== x_db)) begin
            failures++;
            $display("FAIL %s bus: got oe=%0b db=%02h, expected oe=%0b db=%02h",
                     cur_req, db_oe_o, db_o, x_oe, x_db);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic xfer_wr(input logic rs, input logic [7:0] v);
      p_rs = rs; p_db = v;
      if (p_i80) begin
         tick(1); p_wr_n = 1'b0; tick(3); p_wr_n = 1'b1; tick(7);
      end else begin
         p_rw = 1'b0; tick(1); p_en = 1'b1; tick(3); p_en = 1'b0; tick(7);
      end
   endtask

   task automatic xfer_rd(input logic rs);
      p_rs = rs;
      if (p_i80) begin
         tick(1); p_rd_n = 1'b0; tick(3); p_rd_n = 1'b1; tick(7);
      end else begin
         p_rw = 1'b1; tick(1); p_en = 1'b1; tick(3); p_en = 1'b0; tick(1); p_rw = 1'b0; tick(6);
      end
   endtask

   task automatic put_byte(input logic rs, input logic [7:0] v);
      if (bench_full) xfer_wr(rs, v);
      else begin xfer_wr(rs, {v[7:4], 4'h0}); xfer_wr(rs, {v[3:0], 4'h0}); end
   endtask

   task automatic get_byte(input logic rs);
      xfer_rd(rs);
      if (!bench_full) xfer_rd(rs);
   endtask

   task automatic do_reset(input logic i80);
      rst_n = 1'b0; p_i80 = i80; bench_full = 1'b1;
      tick(4); rst_n = 1'b1; tick(4);
   endtask

   bit done = 1'b0;

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state, no pulse, bus idle
      cur_req = "R1";
      do_reset(1'b1);
      tick(6);
      // R2 / R4: strobe-mode writes of both kinds
      cur_req = "R2";
      put_byte(1'b0, 8'h01);
      put_byte(1'b1, 8'hA5);
      cur_req = "R4";
      put_byte(1'b1, 8'h3C);
      // R5 / R6: status and data reads
      cur_req = "R5";
      p_addr = 7'h2A; p_rdata = 8'h96;
      get_byte(1'b0);
      p_busy = 1'b1; get_byte(1'b0); p_busy = 1'b0;
      cur_req = "R6";
      get_byte(1'b1);
      // R11: enable strobe ignored in strobe mode
      cur_req = "R11";
      p_rw = 1'b0; p_db = 8'hEE; tick(1); p_en = 1'b1; tick(3); p_en = 1'b0; tick(7);
      // R9: byte write while busy is dropped
      cur_req = "R9";
      p_busy = 1'b1; put_byte(1'b1, 8'h77); p_busy = 1'b0; tick(2);
      for (int off = 0; off < 5; off++) begin
         p_rs = 1'b1; p_db = 8'h50 + 8'(off); tick(1); p_wr_n = 1'b0; tick(3); p_wr_n = 1'b1;
         tick(off); p_busy = 1'b1; tick(8); p_busy = 1'b0; tick(3);
      end
      // R10: switch to nibble width
      cur_req = "R10";
      put_byte(1'b0, 8'h20); bench_full = 1'b0;
      // R7: nibble-pair writes
      cur_req = "R7";
      put_byte(1'b1, 8'hC3);
      put_byte(1'b0, 8'h0C);
      // R8: nibble-pair reads
      cur_req = "R8";
      p_addr = 7'h5B; get_byte(1'b0);
      p_rdata = 8'h4E; get_byte(1'b1);
      // R9: low nibble taken while busy; high nibble dropped while busy
      cur_req = "R9";
      xfer_wr(1'b1, 8'hD0); p_busy = 1'b1; xfer_wr(1'b1, 8'h70); p_busy = 1'b0;
      p_busy = 1'b1; xfer_wr(1'b1, 8'hF0); p_busy = 1'b0;
      put_byte(1'b1, 8'h69);
      for (int off = 0; off < 5; off++) begin
         xfer_wr(1'b1, 8'h90);
         p_rs = 1'b1; p_db = 8'h10 * 8'(off + 1); tick(1); p_wr_n = 1'b0; tick(3); p_wr_n = 1'b1;
         tick(off); p_busy = 1'b1; tick(8); p_busy = 1'b0; tick(3);
         p_busy = 1'b1; tick(1);
         p_db = 8'hB0; p_wr_n = 1'b0; tick(3); p_wr_n = 1'b1; tick(off); p_busy = 1'b0; tick(8);
      end
      // R10: back to full width from nibble mode
      cur_req = "R10";
      put_byte(1'b0, 8'h30); bench_full = 1'b1;
      put_byte(1'b1, 8'h81);
      // R3: enable-mode protocol
      cur_req = "R3";
      do_reset(1'b0);
      put_byte(1'b0, 8'h06);
      put_byte(1'b1, 8'h5A);
      p_addr = 7'h11; get_byte(1'b0);
      p_rdata = 8'hE7; get_byte(1'b1);
      // R11: separate strobes ignored in enable mode
      cur_req = "R11";
      p_db = 8'h44; tick(1); p_wr_n = 1'b0; tick(3); p_wr_n = 1'b1; tick(7);
      p_rd_n = 1'b0; tick(3); p_rd_n = 1'b1; tick(7);
      // R7 / R8 in enable mode
      cur_req = "R7";
      put_byte(1'b0, 8'h28); bench_full = 1'b0;
      put_byte(1'b1, 8'hB4);
      cur_req = "R8";
      p_rdata = 8'h2D; get_byte(1'b1);
      tick(5);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule